// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stop Gate

This block sits between a clock source and a group of clock outputs and switches the group off and on when an asynchronous, active-low stop request arrives. The request first passes through a flop-chain synchronizer clocked by the ungated source clock. A small controller then decides whether the group's gate is open. Every output gate is re-evaluated only on the falling edge of the source clock. As a result, an output stops parked low, and when it comes back its first high phase is a complete one.

Each gated output also has a configuration enable bit. A cleared bit holds that output low whatever the stop request does. The block also has a companion output that runs freely. Only its own enable bit controls it, and it never responds to the stop request. Once the gate opens, it stays open for a minimum number of cycles. A stop request that arrives inside that window waits until the window ends. The depth of the synchronizer and the minimum run length are parameters, so the same block serves a fast group (a few cycles of latency, a long minimum run) and a slow group (a short minimum run).

Top module: `clk_stop_gate`

## Requirements
- R1: With the minimum run already satisfied, after `stop_n` falls the gated outputs still show the high phases that begin at the first SYNC_STAGES+1 rising edges of `clk_src`, and no high phase after them.
- R2: While the gate is closed, every gated output stays low for the whole clock period, and closing never shortens a high phase that has already started.
- R3: After `stop_n` returns high on a closed gate, the first high phase on the gated outputs begins at rising edge SYNC_STAGES+2 counted from the change, and it is a full high phase.
- R4: Once the gate opens (release of reset or a restart), it stays open for at least MIN_RUN rising edges. A request that arrives earlier is deferred and closes the gate when the window ends. If `stop_n` is held low across reset release, exactly MIN_RUN high phases appear after release.
- R5: When `out_en[i]` is 0, `gclk[i]` stays low regardless of `stop_n`. The enable bits are sampled on the falling edge of `clk_src` and take effect from the next high phase.
- R6: `free_clk` follows `clk_src` whenever `free_en` (sampled on the falling edge) is 1, and it stays low when `free_en` is 0, whatever `stop_n` does.
- R7: `srst` is synchronous and active high. It opens the gate, clears the minimum-run count and loads the synchronizer with "not stopped". While it is high, each `gclk[i]` toggles according to `out_en[i]` alone.
- R8: During the low phase of `clk_src`, every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Ungated source clock; also clocks all internal state |
| srst | input | 1 | Synchronous reset, active high |
| stop_n | input | 1 | Asynchronous stop request, active low |
| out_en | input | NUM_OUT | Per-output enable mask, 1 = may run |
| free_en | input | 1 | Enable of the free-running output |
| gclk | output | NUM_OUT | Gated clock outputs |
| free_clk | output | 1 | Free-running clock output, exempt from stop |

## Verification
The hardest state to reach is a stop request that lands inside the minimum-run window and then either persists or disappears before the window closes. The gate position is never visible directly; it only shows up as missing pulses several cycles later. The stimulus gets there in two ways. First, it holds `stop_n` low across reset release and counts the pulses that follow. Second, it runs a long random phase in which stop toggles, mask changes and short resets collide with the window. A behavioural model checks every high and low phase during both.

// File: rtl/cgate_pkg.sv
package cgate_pkg;

    typedef enum logic {
        GATE_SHUT = 1'b0,
        GATE_OPEN = 1'b1
    } gate_state_e;

    function automatic int cnt_width(input int top);
        return (top > 1) ? $clog2(top) : 1;
    endfunction

endpackage

// File: rtl/cgate_sync.sv
module cgate_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic srst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
        if (srst) begin
            stage_d = '1;
        end
    end

    always_ff @(posedge clk) begin
        stage_q <= stage_d;
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/cgate_run_ctrl.sv
module cgate_run_ctrl
    import cgate_pkg::*;
#(
    parameter int MIN_RUN = 10
) (
    input  logic clk,
    input  logic srst,
    input  logic stop_req,
    output logic run_open
);
    localparam int CW = cnt_width(MIN_RUN);
    localparam logic [CW-1:0] CNT_TOP = CW'(MIN_RUN - 1);

    typedef struct packed {
        gate_state_e    st;
        logic [CW-1:0]  cnt;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        unique case (ctrl_q.st)
            GATE_OPEN: begin
                if (stop_req && (ctrl_q.cnt == CNT_TOP)) begin
                    ctrl_d.st  = GATE_SHUT;
                    ctrl_d.cnt = '0;
                end else if (ctrl_q.cnt != CNT_TOP) begin
                    ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                end
            end
            GATE_SHUT: begin
                if (!stop_req) begin
                    ctrl_d.st  = GATE_OPEN;
                    ctrl_d.cnt = '0;
                end
            end
            default: ctrl_d = ctrl_q;
        endcase
        if (srst) begin
            ctrl_d.st  = GATE_OPEN;
            ctrl_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        ctrl_q <= ctrl_d;
    end

    assign run_open = (ctrl_q.st == GATE_OPEN);
endmodule

// File: rtl/cgate_cell.sv
module cgate_cell (
    input  logic clk,
    input  logic allow,
    input  logic mask,
    output logic en_q,
    output logic gclk
);
    // Gate state moves only while the clock is low.
    always_ff @(negedge clk) begin
        en_q <= allow & mask;
    end

    assign gclk = clk & en_q;
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
    parameter int NUM_OUT     = 5,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_RUN     = 10
) (
    input  logic               clk_src,
    input  logic               srst,
    input  logic               stop_n,
    input  logic [NUM_OUT-1:0] out_en,
    input  logic               free_en,
    output logic [NUM_OUT-1:0] gclk,
    output logic               free_clk
);
    logic               stop_n_sync;
    logic               stop_req;
    logic               run_open;
    logic               allow;
    logic [NUM_OUT-1:0] gate_en;
    logic               free_gate;

    cgate_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk_src),
        .srst     (srst),
        .async_in (stop_n),
        .sync_out (stop_n_sync)
    );

    assign stop_req = ~stop_n_sync;

    cgate_run_ctrl #(.MIN_RUN(MIN_RUN)) u_ctrl (
        .clk      (clk_src),
        .srst     (srst),
        .stop_req (stop_req),
        .run_open (run_open)
    );

    assign allow = srst | run_open;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        cgate_cell u_cell (
            .clk   (clk_src),
            .allow (allow),
            .mask  (out_en[i]),
            .en_q  (gate_en[i]),
            .gclk  (gclk[i])
        );
    end

    cgate_cell u_free (
        .clk   (clk_src),
        .allow (1'b1),
        .mask  (free_en),
        .en_q  (free_gate),
        .gclk  (free_clk)
    );
endmodule

// File: rtl/clk_stop_gate_chk.sv
module clk_stop_gate_chk #(
    parameter int NUM_OUT = 5,
    parameter int MIN_RUN = 10
) (
    input logic               clk_src,
    input logic               srst,
    input logic               stop_req,
    input logic               run_open,
    input logic [NUM_OUT-1:0] out_en,
    input logic [NUM_OUT-1:0] gate_en
);
    localparam int OW = $clog2(MIN_RUN + 1);
    localparam logic [OW-1:0] OPEN_TOP = OW'(MIN_RUN);

    logic [OW-1:0] open_len;

    always_ff @(posedge clk_src) begin
        if (srst || !run_open) begin
            open_len <= '0;
        end else if (open_len != OPEN_TOP) begin
            open_len <= open_len + 1'b1;
        end
    end

    p_off_needs_req_r1: assert property (@(posedge clk_src) disable iff (srst)
        $fell(run_open) |-> $past(stop_req));

    p_restart_needs_clear_r3: assert property (@(posedge clk_src) disable iff (srst)
        ($rose(run_open) && !$past(srst)) |-> !$past(stop_req));

    p_min_run_r4: assert property (@(posedge clk_src) disable iff (srst)
        $fell(run_open) |-> (open_len >= OPEN_TOP));

    p_shut_gate_low_r2: assert property (@(negedge clk_src) disable iff (srst)
        !$past(run_open) |-> (gate_en == '0));

    p_mask_holds_low_r5: assert property (@(negedge clk_src) disable iff (srst)
        (gate_en & ~$past(out_en)) == '0);
endmodule

bind clk_stop_gate clk_stop_gate_chk #(.NUM_OUT(NUM_OUT), .MIN_RUN(MIN_RUN)) u_chk (
    .clk_src  (clk_src),
    .srst     (srst),
    .stop_req (stop_req),
    .run_open (run_open),
    .out_en   (out_en),
    .gate_en  (gate_en)
);

// File: tb/clk_stop_gate_tb_top.sv
`timescale 1ns/100ps
module clk_stop_gate_tb_top;
    localparam int N    = 5;
    localparam int SYNC = 2;
    localparam int MINR = 10;

    logic         clk = 1'b0;
    logic         srst = 1'b1;
    logic         stop_n = 1'b1;
    logic [N-1:0] out_en = '1;
    logic         free_en = 1'b1;
    logic [N-1:0] gclk;
    logic         free_clk;

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R7";

    always #2 clk = ~clk;

    clk_stop_gate #(.NUM_OUT(N), .SYNC_STAGES(SYNC), .MIN_RUN(MINR)) dut_i (
        .clk_src (clk), .srst (srst), .stop_n (stop_n), .out_en (out_en),
        .free_en (free_en), .gclk (gclk), .free_clk (free_clk)
    );

    // Behavioural reference model
    bit           hist[$];
    bit           m_run = 1'b1;
    int           m_cnt = 0;
    logic [N-1:0] m_en = '0;
    logic         m_free = 1'b0;

    initial for (int i = 0; i < SYNC; i++) hist.push_back(1'b1);

    always @(posedge clk) begin
        bit req;
        req = !hist[SYNC-1];
        if (srst) begin
            m_run = 1'b1;
            m_cnt = 0;
            foreach (hist[i]) hist[i] = 1'b1;
        end else begin
            if (m_run) begin
                if (req && m_cnt == MINR - 1) begin
                    m_run = 1'b0;
                    m_cnt = 0;
                end else if (m_cnt < MINR - 1) begin
                    m_cnt++;
                end
            end else if (!req) begin
                m_run = 1'b1;
                m_cnt = 0;
            end
            hist.push_front(stop_n);
            void'(hist.pop_back());
        end
    end

    always @(negedge clk) begin
        m_en   = (srst || m_run) ? out_en : '0;
        m_free = free_en;
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Per-clock comparison in both phases
    initial begin
        repeat (2) @(posedge clk);
        forever begin
            @(posedge clk);
            #1;
            chk(gclk === m_en, cur_tag, "gclk high phase", gclk, m_en);
            chk(free_clk === m_free, "R6", "free_clk high phase", free_clk, m_free);
            #2.5;
            chk(gclk === '0 && free_clk === 1'b0, "R8", "outputs in low phase",
                {free_clk, gclk}, 0);
        end
    end

    task automatic step();
        @(posedge clk);
        #2.5;
    endtask

    task automatic count_pulses(output int n);
        n = 0;
        forever begin
            @(posedge clk);
            #1;
            if (gclk[0] !== 1'b1 || n > 60) break;
            n++;
        end
    endtask

    task automatic edges_to_pulse(output int n);
        n = 0;
        do begin
            @(posedge clk);
            #1;
            n++;
        end while (gclk[0] !== 1'b1 && n < 60);
    endtask

    initial begin
        int n;
        // R7: outputs follow mask while reset is held
        repeat (3) step();
        @(posedge clk); #1;
        chk(gclk === out_en, "R7", "gclk during reset", gclk, out_en);
        step();
        srst = 1'b0;

        // R1: off latency after minimum run is satisfied
        cur_tag = "R1";
        repeat (MINR + 4) step();
        stop_n = 1'b0;
        count_pulses(n);
        chk(n == SYNC + 1, "R1", "pulses after stop", n, SYNC + 1);

        // R2: closed gate holds outputs low, free output keeps running
        cur_tag = "R2";
        n = 0;
        for (int k = 0; k < 20; k++) begin
            @(posedge clk); #1;
            if (gclk !== '0) n++;
        end
        chk(n == 0, "R2", "pulses while closed", n, 0);
        chk(free_clk === 1'b1, "R6", "free_clk while stopped", free_clk, 1);

        // R3: restart latency
        cur_tag = "R3";
        step();
        stop_n = 1'b1;
        edges_to_pulse(n);
        chk(n == SYNC + 2, "R3", "edges to first pulse", n, SYNC + 2);

        // R4: stop held across reset release is deferred by MIN_RUN
        cur_tag = "R4";
        step(); srst = 1'b1; stop_n = 1'b0;
        repeat (3) step();
        srst = 1'b0;
        count_pulses(n);
        chk(n == MINR, "R4", "pulses after reset release", n, MINR);
        // short request inside the window is dropped
        step(); stop_n = 1'b1;
        repeat (SYNC + 4) step();
        stop_n = 1'b0; step(); step(); stop_n = 1'b1;
        repeat (MINR + 6) step();
        @(posedge clk); #1;
        chk(gclk[0] === 1'b1, "R4", "early withdrawn request", gclk[0], 1);

        // R5: mask bits hold outputs low
        cur_tag = "R5";
        step(); out_en = 5'b10101;
        repeat (4) step();
        @(posedge clk); #1;
        chk(gclk === 5'b10101, "R5", "masked outputs", gclk, 5'b10101);
        step(); stop_n = 1'b0;
        repeat (8) step();
        out_en = '1;
        repeat (3) step();
        @(posedge clk); #1;
        chk(gclk === '0, "R5", "mask set while stopped", gclk, 0);

        // R6: free output obeys only its enable
        cur_tag = "R6";
        step(); free_en = 1'b0;
        step();
        @(posedge clk); #1;
        chk(free_clk === 1'b0, "R6", "free_clk disabled", free_clk, 0);
        step(); free_en = 1'b1; stop_n = 1'b1;
        repeat (MINR) step();

        // Random collisions of stop, mask, enable and reset
        cur_tag = "R4";
        for (int c = 0; c < 3000; c++) begin
            step();
            if ($urandom_range(0, 9) == 0) stop_n = ~stop_n;
            if ($urandom_range(0, 29) == 0) out_en = N'($urandom);
            if ($urandom_range(0, 49) == 0) free_en = ~free_en;
            srst = ($urandom_range(0, 199) == 0);
        end
        step();
        srst = 1'b0;
        repeat (4) step();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule